// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a parameterised register (eight stages by default, named A through H from the low end) with four operations chosen by two mode selects: hold, shift toward the high end, shift toward the low end, and synchronous parallel load. Parallel data enters and leaves through one shared bidirectional port. At the block boundary that port is split into a pad input vector, a pad output vector and a single drive-enable. The top level of the chip places the tri-state buffer using those three signals.

Two active-low output enables gate the port drivers. Choosing parallel load also turns the drivers off, so the pad value can be captured. Serial data can enter at either end of the register. Two dedicated outputs always show the lowest and highest stages, whatever the enables are doing, so several copies can be chained in either shift direction. A synchronous active-high reset clears every stage and takes priority over all other inputs.

Top module: `usr_shift_reg`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, every stage becomes 0 after that edge, whatever the mode selects, enables, serial bits or pad value are.
- R2: With `rst` 0, `mode_r`=1 and `mode_l`=1, each stage i takes `pad_in[i]` at the edge (bit 0 is stage A, bit WIDTH-1 is stage H).
- R3: With `rst` 0, `mode_r`=1 and `mode_l`=0, stage A takes `ser_right_in` and each stage i>0 takes the old value of stage i-1 at the edge.
- R4: With `rst` 0, `mode_r`=0 and `mode_l`=1, stage H takes `ser_left_in` and each stage i<WIDTH-1 takes the old value of stage i+1 at the edge.
- R5: With `rst` 0 and both mode selects at 0, all stages keep their values across the edge.
- R6: `pad_oe` is 1 exactly when both bits of `oe_n` are 0 and the mode is not parallel load (not `mode_r`=`mode_l`=1). It follows its inputs in the same cycle, with no clock edge in between.
- R7: The output enables have no effect on the register sequence. Shifting, loading, holding and clearing give the same stage contents whether `pad_oe` is 0 or 1.
- R8: `first_q` always equals stage A and `last_q` always equals stage H, independent of `oe_n` and of the mode.
- R9: `pad_out` presents the stage contents at all times (bit i is stage i), including while `pad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all stages, highest priority |
| mode_r | input | 1 | Mode select; alone it shifts toward stage H |
| mode_l | input | 1 | Mode select; alone it shifts toward stage A; with mode_r it loads |
| oe_n | input | N_OE | Active-low port output enables; all must be 0 to drive |
| ser_right_in | input | 1 | Serial bit entering stage A on a shift toward H |
| ser_left_in | input | 1 | Serial bit entering stage H on a shift toward A |
| pad_in | input | WIDTH | Value seen on the shared port pins |
| pad_out | output | WIDTH | Register contents presented to the port driver |
| pad_oe | output | 1 | Port driver enable |
| first_q | output | 1 | Stage A, always active |
| last_q | output | 1 | Stage H, always active |

## Verification
Every stage result (R1 to R5, R7, R9) is due one rising edge after the inputs that cause it, because each stage is a single register. The end-stage outputs track those stages with no further delay. `pad_oe` is combinational, so it is due in the same cycle as the enables and mode selects that set it. The bench changes inputs only on the falling edge. It checks `pad_oe` a moment after driving, then advances its behavioural model by the coming rising edge and compares the stage outputs at the next falling edge. Directed steps come first, then a long random mix of modes, enables, serial bits, pad values and occasional resets, with every cycle compared against the model.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_RIGHT = 2'b01,
    OP_LEFT  = 2'b10,
    OP_LOAD  = 2'b11
  } usr_op_t;

  function automatic usr_op_t decode_op(input logic toward_hi, input logic toward_lo);
    usr_op_t op;
    unique case ({toward_lo, toward_hi})
      2'b01:   op = OP_RIGHT;
      2'b10:   op = OP_LEFT;
      2'b11:   op = OP_LOAD;
      default: op = OP_HOLD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic    mode_r,
  input  logic    mode_l,
  output usr_op_t op
);

  always_comb begin
    op = decode_op(mode_r, mode_l);
  end

endmodule

// File: rtl/usr_stage.sv
module usr_stage
  import usr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  usr_op_t op,
  input  logic    from_lo,
  input  logic    from_hi,
  input  logic    par,
  output logic    q
);

  logic nxt;

  always_comb begin
    unique case (op)
      OP_RIGHT: nxt = from_lo;
      OP_LEFT:  nxt = from_hi;
      OP_LOAD:  nxt = par;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end

endmodule

// File: rtl/usr_port_ctl.sv
module usr_port_ctl
  import usr_pkg::*;
#(
  parameter int N_OE = 2
) (
  input  logic [N_OE-1:0] oe_n,
  input  usr_op_t         op,
  output logic            drive
);

  logic all_enabled;

  always_comb begin
    all_enabled = ~(|oe_n);
    drive       = all_enabled && (op != OP_LOAD);
  end

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int N_OE  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_r,
  input  logic             mode_l,
  input  logic [N_OE-1:0]  oe_n,
  input  logic             ser_right_in,
  input  logic             ser_left_in,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic             pad_oe,
  output logic             first_q,
  output logic             last_q
);

  localparam int TOP = WIDTH - 1;

  usr_op_t          op;
  logic [WIDTH-1:0] stq;

  usr_mode_dec u_dec (
    .mode_r (mode_r),
    .mode_l (mode_l),
    .op     (op)
  );

  usr_port_ctl #(.N_OE(N_OE)) u_port (
    .oe_n  (oe_n),
    .op    (op),
    .drive (pad_oe)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic lo_src;
    logic hi_src;
    if (i == 0) begin : g_lo_end
      assign lo_src = ser_right_in;
    end else begin : g_lo_mid
      assign lo_src = stq[i-1];
    end
    if (i == TOP) begin : g_hi_end
      assign hi_src = ser_left_in;
    end else begin : g_hi_mid
      assign hi_src = stq[i+1];
    end
    usr_stage u_bit (
      .clk     (clk),
      .rst     (rst),
      .op      (op),
      .from_lo (lo_src),
      .from_hi (hi_src),
      .par     (pad_in[i]),
      .q       (stq[i])
    );
  end

  assign pad_out = stq;
  assign first_q = stq[0];
  assign last_q  = stq[TOP];

endmodule

// File: rtl/usr_shift_reg_chk.sv
module usr_shift_reg_chk #(
  parameter int WIDTH = 8,
  parameter int N_OE  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_r,
  input logic             mode_l,
  input logic [N_OE-1:0]  oe_n,
  input logic             ser_right_in,
  input logic             ser_left_in,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic             pad_oe,
  input logic             first_q,
  input logic             last_q
);

  // R1: a clear edge leaves zero
  a_r1_clear: assert property (@(posedge clk) $past(rst) |-> (pad_out == '0));

  // R2
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (mode_r && mode_l) |=> (pad_out == $past(pad_in)));

  // R3
  a_r3_shift_hi: assert property (@(posedge clk) disable iff (rst)
    (mode_r && !mode_l) |=> (pad_out == {$past(pad_out[WIDTH-2:0]), $past(ser_right_in)}));

  // R4
  a_r4_shift_lo: assert property (@(posedge clk) disable iff (rst)
    (!mode_r && mode_l) |=> (pad_out == {$past(ser_left_in), $past(pad_out[WIDTH-1:1])}));

  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!mode_r && !mode_l) |=> $stable(pad_out));

  // R6: any raised enable or a load keeps the driver off
  a_r6_drive_off: assert property (@(posedge clk) disable iff (rst)
    ((|oe_n) || (mode_r && mode_l)) |-> !pad_oe);

  // R6: enabled and not loading drives
  a_r6_drive_on: assert property (@(posedge clk) disable iff (rst)
    ((oe_n == '0) && !(mode_r && mode_l)) |-> pad_oe);

  // R8
  a_r8_end_taps: assert property (@(posedge clk) disable iff (rst)
    (first_q == pad_out[0]) && (last_q == pad_out[WIDTH-1]));

endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH), .N_OE(N_OE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_r       (mode_r),
  .mode_l       (mode_l),
  .oe_n         (oe_n),
  .ser_right_in (ser_right_in),
  .ser_left_in  (ser_left_in),
  .pad_in       (pad_in),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .first_q      (first_q),
  .last_q       (last_q)
);

// File: tb/usr_shift_reg_test.sv
`timescale 1ns/1ps
module usr_shift_reg_test;

  localparam int W  = 8;
  localparam int NO = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_r = 1'b0;
  logic          mode_l = 1'b0;
  logic [NO-1:0] oe_n = '1;
  logic          ser_right_in = 1'b0;
  logic          ser_left_in = 1'b0;
  logic [W-1:0]  pad_in = '0;
  logic [W-1:0]  pad_out;
  logic          pad_oe;
  logic          first_q;
  logic          last_q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit    model [W];
  string last_tag = "R1";
  bit    last_oe_off = 0;

  always #5 clk = ~clk;

  usr_shift_reg #(.WIDTH(W), .N_OE(NO)) uut (
    .clk(clk), .rst(rst), .mode_r(mode_r), .mode_l(mode_l), .oe_n(oe_n),
    .ser_right_in(ser_right_in), .ser_left_in(ser_left_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .first_q(first_q), .last_q(last_q)
  );

  function automatic logic [W-1:0] model_vec();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = model[i];
    return v;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    logic [W-1:0] e;
    e = model_vec();
    check({last_tag, "/R9 contents"}, pad_out, e);
    if (last_oe_off) check("R7 contents with driver off", pad_out, e);
    check("R8 first_q", {{(W-1){1'b0}}, first_q}, {{(W-1){1'b0}}, e[0]});
    check("R8 last_q",  {{(W-1){1'b0}}, last_q},  {{(W-1){1'b0}}, e[W-1]});
  endtask

  task automatic step_model();
    bit old [W];
    for (int i = 0; i < W; i++) old[i] = model[i];
    last_oe_off = (oe_n != '0);
    if (rst) begin
      for (int i = 0; i < W; i++) model[i] = 0;
      last_tag = "R1";
    end else if (mode_r && mode_l) begin
      for (int i = 0; i < W; i++) model[i] = pad_in[i];
      last_tag = "R2";
    end else if (mode_r) begin
      model[0] = ser_right_in;
      for (int i = 1; i < W; i++) model[i] = old[i-1];
      last_tag = "R3";
    end else if (mode_l) begin
      model[W-1] = ser_left_in;
      for (int i = 0; i < W-1; i++) model[i] = old[i+1];
      last_tag = "R4";
    end else begin
      last_tag = "R5";
    end
  endtask

  // drive at falling edge, check drive-enable, predict the coming edge, compare next falling edge
  task automatic cyc(input bit r, input bit mr, input bit ml, input logic [NO-1:0] oe,
                     input bit sr, input bit sl, input logic [W-1:0] p);
    bit exp_oe;
    rst = r; mode_r = mr; mode_l = ml; oe_n = oe;
    ser_right_in = sr; ser_left_in = sl; pad_in = p;
    #1;
    exp_oe = (oe == '0) && !(mr && ml);
    check("R6 pad_oe", {{(W-1){1'b0}}, pad_oe}, {{(W-1){1'b0}}, exp_oe});
    step_model();
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    for (int i = 0; i < W; i++) model[i] = 0;
    @(negedge clk);
    cyc(1, 1, 0, 2'b00, 1, 1, 8'hFF);
    check("R1 reset state", pad_out, '0);
    cyc(0, 1, 1, 2'b00, 0, 0, 8'hA5);          // R2 load
    check("R2 load A5", pad_out, 8'hA5);
    cyc(0, 0, 0, 2'b00, 1, 1, 8'h00);          // R5 hold
    check("R5 hold A5", pad_out, 8'hA5);
    cyc(0, 1, 0, 2'b00, 1, 0, 8'h00);          // R3 shift toward H
    check("R3 shift in 1", pad_out, 8'h4B);
    cyc(0, 0, 1, 2'b01, 0, 1, 8'h00);          // R4 shift toward A, driver off
    check("R4 shift in 1 at H", pad_out, 8'hA5);
    cyc(0, 1, 0, 2'b10, 0, 0, 8'h00);          // R7 shift with enables high
    check("R7 shift while disabled", pad_out, 8'h4A);
    cyc(1, 1, 1, 2'b11, 1, 1, 8'hFF);          // R1 reset beats load
    check("R1 reset overrides load", pad_out, 8'h00);
    for (int k = 0; k < W; k++) cyc(0, 1, 0, 2'b00, 1, 0, 8'h00);
    check("R3 fill ones", pad_out, 8'hFF);
    check("R8 last_q after fill", {7'b0, last_q}, 8'h01);
    for (int k = 0; k < W; k++) cyc(0, 0, 1, 2'b11, 0, 0, 8'h00);
    check("R4 drain zeros", pad_out, 8'h00);
    for (int k = 0; k < 4000; k++) begin
      int rr;
      rr = $urandom_range(0, 31);
      cyc(rr == 0, 1'($urandom), 1'($urandom), NO'($urandom), 1'($urandom),
          1'($urandom), W'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule